// File: doc/BRIEF.md
# Multi-format PCM serial audio receiver

This block turns a stereo PCM bit stream into parallel 24-bit left and right samples. The stream arrives on one data line and is clocked by a bit clock and a frame clock. The level of the frame clock tells which channel is on the line. Two bit-clock/frame-clock pairs enter the block, and a select input decides which pair times the data line. All three serial signals are brought into the system clock domain and sampled on the rising edge of the chosen bit clock.

A 3-bit format code picks the framing. Three framings are supported: left-justified, I2S, and a right-justified framing with a word length of 16, 18, 20 or 24 bits. Words are two's complement and arrive MSB first. A right-justified word shorter than 24 bits is sign-extended to 24 bits, so it keeps its numeric value. When both channels of a frame have been collected, the block presents them together on its outputs with a single-cycle valid pulse. The two reserved format codes produce no output at all.

Each channel slot must be at least 25 bit clocks long. The system clock must run at least six times faster than the bit clock.

Top module: `pcm_fmt_rx`

## Requirements
- R1: While reset is held and just after it is released, `word_valid` is 0 and both output words are 0.
- R2: Format code 000 (left-justified): a high frame clock marks the left channel. The first 24 bits of a slot, MSB first, form the word.
- R3: Format code 001 (I2S): a low frame clock marks the left channel. The bit sampled on the first bit-clock rising edge of a slot is skipped, and the next 24 bits form the word.
- R4: Format code 010 (right-justified, 16 bits): a high frame clock marks left. The word is the last 16 bits before the frame-clock edge, sign-extended to 24 bits.
- R5: Format code 011 (right-justified, 24 bits): the word is the last 24 bits before the frame-clock edge.
- R6: Format code 100 (right-justified, 20 bits): the word is the last 20 bits before the edge, sign-extended.
- R7: Format code 101 (right-justified, 18 bits): the word is the last 18 bits before the edge, sign-extended.
- R8: With format code 110 or 111, `word_valid` is never asserted.
- R9: `pair_sel` = 0 times the data line with `bclk_a`/`lrck_a`. `pair_sel` = 1 uses `bclk_b`/`lrck_b`. The unselected pair has no effect.
- R10: Each completed left-then-right frame gives exactly one `word_valid` pulse one system clock long. On that pulse both words of that frame are present. The first partial slot after reset is discarded.
- R11: Slot bits outside the word have no effect on the output. For left-justified and I2S these are the bits after the word. For right-justified they are the bits before the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_a | input | 1 | Bit clock, pair A |
| lrck_a | input | 1 | Frame clock, pair A |
| bclk_b | input | 1 | Bit clock, pair B |
| lrck_b | input | 1 | Frame clock, pair B |
| sdata | input | 1 | Serial audio data line |
| pair_sel | input | 1 | Clock pair select: 0 = A, 1 = B |
| fmt | input | 3 | Framing format code |
| left_word | output | 24 | Left sample of the last frame |
| right_word | output | 24 | Right sample of the last frame |
| word_valid | output | 1 | One-cycle pulse when a new frame is presented |

## Verification
Wrong internal state shows up at the ports within one frame. A bit counter that starts its slot off by one shifts every left-justified or I2S word by one bit, and the first pulse after the fault carries a doubled or halved value. A bad channel-polarity decision or a stale "left seen" flag makes pulses go missing or come in pairs. This is visible as a wrong pulse count once the group of frames has ended. A sign-extension fault in a short right-justified mode only shows on negative words, so each group starts with directed extreme values before the random ones.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic [2:0] {
    FMT_LJ    = 3'b000,
    FMT_I2S   = 3'b001,
    FMT_RJ16  = 3'b010,
    FMT_RJ24  = 3'b011,
    FMT_RJ20  = 3'b100,
    FMT_RJ18  = 3'b101,
    FMT_RSV6  = 3'b110,
    FMT_RSV7  = 3'b111
  } fmt_e;

  function automatic logic fmt_reserved(input logic [2:0] f);
    return f[2] & f[1];
  endfunction

  // frame-clock level that marks the left channel
  function automatic logic fmt_left_level(input logic [2:0] f);
    return (f != FMT_I2S);
  endfunction

  function automatic logic fmt_is_rj(input logic [2:0] f);
    return (f != FMT_LJ) && (f != FMT_I2S);
  endfunction

  function automatic int unsigned fmt_rj_len(input logic [2:0] f);
    case (f)
      FMT_RJ16: return 16;
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      default:  return 24;
    endcase
  endfunction
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= '0;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_rx_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int MAX_SLOT = 64,
  localparam int CNT_W   = $clog2(MAX_SLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_evt,
  input  logic              lr,
  input  logic              din,
  input  logic [2:0]        fmt,
  output logic              slot_done,
  output logic              slot_left,
  output logic [WORD_W-1:0] slot_word
);
  logic              started, armed, prev_lr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] run_sr, win_sr;

  // named internal events
  logic              boundary;
  logic [CNT_W-1:0]  bit_idx;
  logic              in_window;
  logic [CNT_W-1:0]  skip;

  function automatic logic [WORD_W-1:0] extend_low(input logic [WORD_W-1:0] v,
                                                   input int unsigned n);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++)
      r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  assign boundary  = bit_evt && started && (lr != prev_lr);
  assign bit_idx   = boundary ? '0 : bit_cnt;
  assign skip      = (fmt == FMT_I2S) ? CNT_W'(1) : '0;
  assign in_window = (bit_idx >= skip) && (bit_idx < skip + CNT_W'(WORD_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      armed   <= 1'b0;
      prev_lr <= 1'b0;
      bit_cnt <= '0;
      run_sr  <= '0;
      win_sr  <= '0;
    end else if (bit_evt) begin
      started <= 1'b1;
      prev_lr <= lr;
      if (boundary) armed <= 1'b1;
      if (bit_idx != CNT_W'(MAX_SLOT)) bit_cnt <= bit_idx + 1'b1;
      else bit_cnt <= bit_idx;
      run_sr <= {run_sr[WORD_W-2:0], din};
      if (in_window) win_sr <= {win_sr[WORD_W-2:0], din};
    end
  end

  assign slot_done = boundary && armed;
  assign slot_left = (prev_lr == fmt_left_level(fmt));
  assign slot_word = fmt_is_rj(fmt) ? extend_low(run_sr, fmt_rj_len(fmt)) : win_sr;

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (bit_cnt == CNT_W'(1)));  // R3
endmodule

// File: rtl/pcm_rx_pair.sv
module pcm_rx_pair
  import pcm_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fmt,
  input  logic              slot_done,
  input  logic              slot_left,
  input  logic [WORD_W-1:0] slot_word,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              word_valid
);
  logic [WORD_W-1:0] left_hold;
  logic              have_left;
  logic              accept;

  assign accept = slot_done && !fmt_reserved(fmt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold  <= '0;
      have_left  <= 1'b0;
      left_word  <= '0;
      right_word <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (accept) begin
        if (slot_left) begin
          left_hold <= slot_word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_word  <= left_hold;
          right_word <= slot_word;
          word_valid <= 1'b1;
          have_left  <= 1'b0;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);  // R10
  AST_VALID_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(slot_done));  // R10
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_reserved(fmt) |=> !word_valid);  // R8
  AST_RJ16_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(fmt) == FMT_RJ16) |->
      ($countones(right_word[WORD_W-1:15]) == 0 ||
       $countones(right_word[WORD_W-1:15]) == WORD_W-15));  // R4
endmodule

// File: rtl/pcm_fmt_rx.sv
module pcm_fmt_rx
  import pcm_rx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int MAX_SLOT    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_a,
  input  logic              lrck_a,
  input  logic              bclk_b,
  input  logic              lrck_b,
  input  logic              sdata,
  input  logic              pair_sel,
  input  logic [2:0]        fmt,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              word_valid
);
  localparam int NSIG = 5;

  logic [NSIG-1:0]   raw, syncd;
  logic              sel_bclk, sel_lr, bclk_d, bit_evt;
  logic              slot_done, slot_left;
  logic [WORD_W-1:0] slot_word;

  assign raw = {sdata, lrck_b, bclk_b, lrck_a, bclk_a};

  pcm_rx_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(raw), .d_out(syncd));

  assign sel_bclk = pair_sel ? syncd[2] : syncd[0];
  assign sel_lr   = pair_sel ? syncd[3] : syncd[1];

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_d <= 1'b0;
    else bclk_d <= sel_bclk;
  end
  assign bit_evt = sel_bclk && !bclk_d;

  pcm_rx_slot #(.WORD_W(WORD_W), .MAX_SLOT(MAX_SLOT)) slot_i (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .lr(sel_lr), .din(syncd[4]),
    .fmt(fmt), .slot_done(slot_done), .slot_left(slot_left), .slot_word(slot_word));

  pcm_rx_pair #(.WORD_W(WORD_W)) pair_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .slot_done(slot_done),
    .slot_left(slot_left), .slot_word(slot_word), .left_word(left_word),
    .right_word(right_word), .word_valid(word_valid));

  AST_EVT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> !bit_evt);  // R9
endmodule

// File: tb/pcm_fmt_rx_tb.sv
module pcm_fmt_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_a = 1'b0, lrck_a = 1'b0, bclk_b = 1'b0, lrck_b = 1'b0;
  logic sdata = 1'b0, pair_sel = 1'b0;
  logic [2:0] fmt = 3'b000;
  logic [23:0] left_word, right_word;
  logic word_valid;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [23:0] exp_l [64];
  logic [23:0] exp_r [64];
  int nexp = 0, got = 0;
  string cur_req = "R2";
  logic prev_valid = 1'b0;

  always #2 clk = ~clk;

  pcm_fmt_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_a(bclk_a), .lrck_a(lrck_a), .bclk_b(bclk_b),
    .lrck_b(lrck_b), .sdata(sdata), .pair_sel(pair_sel), .fmt(fmt),
    .left_word(left_word), .right_word(right_word), .word_valid(word_valid));

  function automatic int rj_bits(input logic [2:0] f);
    if (f == 3'b010) return 16;
    if (f == 3'b100) return 20;
    if (f == 3'b101) return 18;
    return 24;
  endfunction

  function automatic bit is_rj(input logic [2:0] f);
    return f >= 3'b010;
  endfunction

  // expected 24-bit value of a word as the requirements define it
  function automatic logic [23:0] expect_word(input logic [2:0] f, input logic [23:0] w);
    int n;
    logic [23:0] mask, v;
    if (!is_rj(f)) return w;
    n = rj_bits(f);
    mask = (24'h1 << n) - 24'h1;
    if (n == 24) mask = 24'hFFFFFF;
    v = w & mask;
    if (w[n-1]) v = v | ~mask;
    return v;
  endfunction

  // 32-bit slot, bit 31 sent first
  function automatic logic [31:0] build_slot(input logic [2:0] f, input logic [23:0] w,
                                             input logic [31:0] junk);
    logic [31:0] s, mask;
    int n;
    if (f == 3'b000) return {w, junk[7:0]};
    if (f == 3'b001) return {junk[8], w, junk[6:0]};
    n = rj_bits(f);
    mask = (32'h1 << n) - 32'h1;
    s = (junk & ~mask) | ({8'h0, w} & mask);
    return s;
  endfunction

  task automatic drive_bit(input logic lr, input logic b);
    @(negedge clk);
    sdata = b;
    if (pair_sel) begin
      lrck_b = lr; lrck_a = ~lr; bclk_b = 1'b0; bclk_a = 1'b1;
    end else begin
      lrck_a = lr; lrck_b = ~lr; bclk_a = 1'b0; bclk_b = 1'b1;
    end
    repeat (4) @(negedge clk);
    if (pair_sel) begin bclk_b = 1'b1; bclk_a = 1'b0; end
    else begin bclk_a = 1'b1; bclk_b = 1'b0; end
    repeat (3) @(negedge clk);
  endtask

  task automatic send_slot(input logic lr, input logic [31:0] s);
    for (int i = 31; i >= 0; i--) drive_bit(lr, s[i]);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one group: reset, preamble, frames, trailer; then count check
  task automatic run_group(input logic [2:0] f, input logic sel, input int nfr,
                           input string req);
    logic lvl;
    logic [23:0] wl, wr;
    logic [31:0] jl, jr;
    fmt = f; pair_sel = sel; cur_req = req;
    do_reset();
    nexp = 0; got = 0;
    lvl = (f == 3'b001) ? 1'b0 : 1'b1;
    for (int i = 0; i < 8; i++) drive_bit(~lvl, 1'($urandom));
    for (int k = 0; k < nfr; k++) begin
      jl = $urandom; jr = $urandom;
      case (k)
        0: begin wl = 24'h800000 >> (24 - rj_bits(f)); wr = 24'h000000; jr = 32'hFFFFFFFF; end
        1: begin wl = 24'hFFFFFF; wr = 24'h7FFFFF >> (24 - rj_bits(f)); jl = 32'h0; end
        default: begin wl = 24'($urandom); wr = 24'($urandom); end
      endcase
      if (f == 3'b000 || f == 3'b001) begin
        if (k == 0) wl = 24'h800000;
        if (k == 1) wr = 24'h7FFFFF;
      end
      exp_l[nexp] = expect_word(f, wl);
      exp_r[nexp] = expect_word(f, wr);
      if (f[2] && f[1]) nexp = nexp; else nexp++;
      send_slot(lvl, build_slot(f, wl, jl));
      send_slot(~lvl, build_slot(f, wr, jr));
    end
    for (int i = 0; i < 8; i++) drive_bit(lvl, 1'($urandom));
    repeat (20) @(negedge clk);
    check(got == nexp, (f[2] && f[1]) ? "R8" : "R10", "valid pulse count",
          24'(got), 24'(nexp));
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (word_valid) begin
        if (got < nexp) begin
          check(left_word == exp_l[got], cur_req, "left word", left_word, exp_l[got]);
          check(right_word == exp_r[got], cur_req, "right word", right_word, exp_r[got]);
          if (got < 2)
            check(left_word == exp_l[got] && right_word == exp_r[got], "R11",
                  "directed word with junk", right_word, exp_r[got]);
        end
        got++;
        if (prev_valid)
          check(1'b0, "R10", "valid longer than one cycle", 24'd1, 24'd0);
      end
      prev_valid <= word_valid;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(word_valid == 1'b0, "R1", "valid in reset", 24'(word_valid), 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(left_word == 24'd0 && right_word == 24'd0, "R1", "words after reset",
          left_word | right_word, 24'd0);
    check(word_valid == 1'b0, "R1", "valid after reset", 24'(word_valid), 24'd0);

    run_group(3'b000, 1'b0, 6, "R2");
    run_group(3'b001, 1'b0, 6, "R3");
    run_group(3'b010, 1'b0, 6, "R4");
    run_group(3'b011, 1'b0, 6, "R5");
    run_group(3'b100, 1'b0, 6, "R6");
    run_group(3'b101, 1'b0, 6, "R7");
    run_group(3'b000, 1'b1, 5, "R9");
    run_group(3'b001, 1'b1, 5, "R9");
    run_group(3'b100, 1'b1, 5, "R9");
    run_group(3'b110, 1'b0, 3, "R8");
    run_group(3'b111, 1'b1, 3, "R8");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule